// File: doc/BRIEF.md
# Value Predictor Access Filter

This block decides, one instruction at a time, whether that instruction may look up the value predictor and whether it may write its result back into it. The decision uses a small history that travels with each instruction. That history holds three saturating counters and an operation class.

At fetch, the block checks the class and the three counters. A read is granted only to instructions that produce a result and that no filter currently blocks. The three filters are:

- **Quick-completion filter:** the instruction finished before its prediction arrived.
- **Unused-prediction filter:** the prediction was never consumed.
- **Misprediction filter:** the prediction was wrong.

At retire, the per-instance outcome flags move the counters one step up or down, and the updated history comes out for write-back. A clear strobe wipes the history when it is rebuilt. The misprediction counter latches once it is full and only the clear strobe releases it. Write permission is tied to whether this same dynamic instance actually read the predictor at fetch.

All outputs are registered. A request presented on one rising edge appears on the outputs after that edge, together with a valid flag.

Top module: `vpf_access_filter`

## Requirements
- R1: Operation classes 0 to 3 produce a result (integer, load, multiply/divide, floating point). Classes 4 to 7 (branch, store, no-op, system) never get `rd_allow` = 1.
- R2: A quick-completion count of 2 or more blocks the read.
- R3: An unused-prediction count of 2 or more blocks the read.
- R4: The misprediction count blocks the read only at its maximum, 7. Values 0 to 6 do not block.
- R5: `rd_allow` is 1 exactly when the class is result-producing and none of R2, R3 or R4 blocks.
- R6: When `retire` and `did_read` are both 1, each counter moves as follows:
  - It goes up by one when its own flag is set: `ev_quick` for the quick count, `ev_unused` for the unused count, `ev_misp` for the misprediction count.
  - It goes down by one when its flag is clear.
  - It saturates at 0 and at its maximum and never wraps.
- R7: A misprediction count of 7 on the input comes out as 7, whatever the flags are, unless `hist_clear` is set.
- R8: When `retire` or `did_read` is 0, all three counters come out unchanged and the outcome flags have no effect.
- R9: `wr_allow` is 1 exactly when the request had both `retire` and `did_read` set.
- R10: `hist_clear` drives all three output counters to 0 and wins over any outcome flag. The read decision then depends on the class alone.
- R11: Outputs reflect the request one clock edge later. `out_valid` follows `in_valid`, and when `in_valid` was 0, both allow outputs are 0.
- R12: A synchronous active-high `rst` forces every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| op_class | input | 3 | Operation class of the instruction |
| quick_cnt_in | input | QW | Quick-completion history count |
| unused_cnt_in | input | UW | Unused-prediction history count |
| misp_cnt_in | input | MW | Misprediction history count |
| retire | input | 1 | Request carries retire outcomes |
| did_read | input | 1 | This instance read the predictor at fetch |
| ev_quick | input | 1 | Result produced before the prediction arrived |
| ev_unused | input | 1 | Prediction not consumed |
| ev_misp | input | 1 | Prediction was wrong |
| hist_clear | input | 1 | Discard and restart the history |
| out_valid | output | 1 | Registered request valid |
| rd_allow | output | 1 | Predictor read permitted |
| wr_allow | output | 1 | Predictor update permitted |
| quick_cnt_out | output | QW | Updated quick-completion count |
| unused_cnt_out | output | UW | Updated unused-prediction count |
| misp_cnt_out | output | MW | Updated misprediction count |

## Verification
The assertions check on every cycle the rules that link one request to its registered result:
- the class gate;
- the misprediction latch and its read block;
- the write permission following the fetch-time read;
- frozen history without a read;
- the clear's priority;
- the one-edge valid pipeline.

Only the bench's scenarios can show the exact up/down arithmetic at both saturation ends for every counter value and flag combination. The same holds for the blocking thresholds of the quick and unused filters. The bench also replays long histories in which each instance's read outcome feeds its own update, which shows the misprediction counter climbing to seven and then holding.

// File: rtl/vpf_pkg.sv
package vpf_pkg;

  // Operation classes carried with each instruction.
  typedef enum logic [2:0] {
    OPC_INT    = 3'd0,
    OPC_LOAD   = 3'd1,
    OPC_MULDIV = 3'd2,
    OPC_FP     = 3'd3,
    OPC_BRANCH = 3'd4,
    OPC_STORE  = 3'd5,
    OPC_NOP    = 3'd6,
    OPC_SYS    = 3'd7
  } opclass_e;

  localparam int OPC_W = 3;

  // Default set of classes that write a destination register.
  localparam logic [(1<<OPC_W)-1:0] RESULT_CLASSES = 8'h0F;

  // Per-counter update control.
  typedef struct packed {
    logic clr;  // wipe history (highest priority)
    logic en;   // outcome events apply
    logic up;   // step direction when enabled
  } cnt_ctl_t;

endpackage

// File: rtl/vpf_sat_counter.sv
module vpf_sat_counter
  import vpf_pkg::*;
#(
  parameter int W      = 2,
  parameter int THRESH = 2,
  parameter bit STICKY = 1'b0
) (
  input  logic [W-1:0] cnt_in,
  input  cnt_ctl_t     ctl,
  output logic [W-1:0] cnt_next,
  output logic         block
);

  localparam logic [W-1:0] CMAX = '1;
  localparam logic [W-1:0] THR  = W'(THRESH);

  logic hold;

  // Variant selection: a sticky counter freezes once full.
  generate
    if (STICKY) begin : g_sticky
      assign hold = (cnt_in == CMAX);
    end else begin : g_plain
      assign hold = 1'b0;
    end
  endgenerate

  always_comb begin
    cnt_next = cnt_in;
    if (ctl.clr) begin
      cnt_next = '0;
    end else if (ctl.en && !hold) begin
      if (ctl.up) begin
        if (cnt_in != CMAX) cnt_next = cnt_in + 1'b1;
      end else begin
        if (cnt_in != '0) cnt_next = cnt_in - 1'b1;
      end
    end
  end

  assign block = (cnt_in >= THR);

endmodule

// File: rtl/vpf_type_gate.sv
module vpf_type_gate
  import vpf_pkg::*;
#(
  parameter logic [(1<<OPC_W)-1:0] RESULT_MASK = RESULT_CLASSES
) (
  input  opclass_e cls,
  output logic     pass
);

  assign pass = RESULT_MASK[cls];

endmodule

// File: rtl/vpf_access_filter.sv
module vpf_access_filter
  import vpf_pkg::*;
#(
  parameter int QW       = 2,
  parameter int Q_THRESH = 2,
  parameter int UW       = 2,
  parameter int U_THRESH = 2,
  parameter int MW       = 3,
  parameter logic [(1<<OPC_W)-1:0] RESULT_MASK = RESULT_CLASSES
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [2:0]    op_class,
  input  logic [QW-1:0] quick_cnt_in,
  input  logic [UW-1:0] unused_cnt_in,
  input  logic [MW-1:0] misp_cnt_in,
  input  logic          retire,
  input  logic          did_read,
  input  logic          ev_quick,
  input  logic          ev_unused,
  input  logic          ev_misp,
  input  logic          hist_clear,
  output logic          out_valid,
  output logic          rd_allow,
  output logic          wr_allow,
  output logic [QW-1:0] quick_cnt_out,
  output logic [UW-1:0] unused_cnt_out,
  output logic [MW-1:0] misp_cnt_out
);

  // Mispredict filter only blocks when fully saturated.
  localparam int M_THRESH = (1 << MW) - 1;

  logic          gate_pass;
  logic          q_blk, u_blk, m_blk;
  logic          upd_en, clr;
  logic          rd_ok;
  logic [QW-1:0] q_nxt;
  logic [UW-1:0] u_nxt;
  logic [MW-1:0] m_nxt;
  cnt_ctl_t      q_ctl, u_ctl, m_ctl;

  assign upd_en = in_valid & retire & did_read;
  assign clr    = in_valid & hist_clear;

  assign q_ctl = '{clr: clr, en: upd_en, up: ev_quick};
  assign u_ctl = '{clr: clr, en: upd_en, up: ev_unused};
  assign m_ctl = '{clr: clr, en: upd_en, up: ev_misp};

  vpf_type_gate #(.RESULT_MASK(RESULT_MASK)) u_gate (
    .cls  (opclass_e'(op_class)),
    .pass (gate_pass)
  );

  vpf_sat_counter #(.W(QW), .THRESH(Q_THRESH), .STICKY(1'b0)) u_quick (
    .cnt_in   (quick_cnt_in),
    .ctl      (q_ctl),
    .cnt_next (q_nxt),
    .block    (q_blk)
  );

  vpf_sat_counter #(.W(UW), .THRESH(U_THRESH), .STICKY(1'b0)) u_unused (
    .cnt_in   (unused_cnt_in),
    .ctl      (u_ctl),
    .cnt_next (u_nxt),
    .block    (u_blk)
  );

  vpf_sat_counter #(.W(MW), .THRESH(M_THRESH), .STICKY(1'b1)) u_misp (
    .cnt_in   (misp_cnt_in),
    .ctl      (m_ctl),
    .cnt_next (m_nxt),
    .block    (m_blk)
  );

  // A cleared history has no blocking counts; only the class gate remains.
  assign rd_ok = gate_pass & (clr | ~(q_blk | u_blk | m_blk));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid      <= 1'b0;
      rd_allow       <= 1'b0;
      wr_allow       <= 1'b0;
      quick_cnt_out  <= '0;
      unused_cnt_out <= '0;
      misp_cnt_out   <= '0;
    end else begin
      out_valid      <= in_valid;
      rd_allow       <= in_valid & rd_ok;
      wr_allow       <= upd_en;
      quick_cnt_out  <= q_nxt;
      unused_cnt_out <= u_nxt;
      misp_cnt_out   <= m_nxt;
    end
  end

endmodule

// File: rtl/vpf_access_filter_chk.sv
module vpf_access_filter_chk #(
  parameter int QW = 2,
  parameter int UW = 2,
  parameter int MW = 3,
  parameter logic [7:0] RESULT_MASK = 8'h0F
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [2:0]    op_class,
  input logic [QW-1:0] quick_cnt_in,
  input logic [UW-1:0] unused_cnt_in,
  input logic [MW-1:0] misp_cnt_in,
  input logic          retire,
  input logic          did_read,
  input logic          ev_quick,
  input logic          ev_unused,
  input logic          ev_misp,
  input logic          hist_clear,
  input logic          out_valid,
  input logic          rd_allow,
  input logic          wr_allow,
  input logic [QW-1:0] quick_cnt_out,
  input logic [UW-1:0] unused_cnt_out,
  input logic [MW-1:0] misp_cnt_out
);

  localparam logic [MW-1:0] MMAX = '1;

  // R1
  type_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !$past(RESULT_MASK[op_class])) |-> !rd_allow);

  // R4
  misp_block_chk: assert property (@(posedge clk) disable iff (rst)
    rd_allow |-> $past(misp_cnt_in != MMAX || hist_clear));

  // R6
  quick_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(retire && did_read && !hist_clear && ev_quick))
      |-> (quick_cnt_out >= $past(quick_cnt_in)));

  // R7
  misp_latch_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(misp_cnt_in == MMAX && !hist_clear))
      |-> (misp_cnt_out == MMAX));

  // R8
  frozen_hist_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(!hist_clear && !(retire && did_read)))
      |-> (quick_cnt_out == $past(quick_cnt_in) &&
           unused_cnt_out == $past(unused_cnt_in) &&
           misp_cnt_out == $past(misp_cnt_in)));

  // R9
  wr_follow_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (wr_allow == $past(retire && did_read)));

  // R10
  clear_prio_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(hist_clear))
      |-> (quick_cnt_out == '0 && unused_cnt_out == '0 && misp_cnt_out == '0));

  // R11
  valid_pipe_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (out_valid == $past(in_valid)));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!rd_allow && !wr_allow));

endmodule

bind vpf_access_filter vpf_access_filter_chk #(
  .QW(QW), .UW(UW), .MW(MW), .RESULT_MASK(RESULT_MASK)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op_class(op_class),
  .quick_cnt_in(quick_cnt_in), .unused_cnt_in(unused_cnt_in),
  .misp_cnt_in(misp_cnt_in), .retire(retire), .did_read(did_read),
  .ev_quick(ev_quick), .ev_unused(ev_unused), .ev_misp(ev_misp),
  .hist_clear(hist_clear), .out_valid(out_valid), .rd_allow(rd_allow),
  .wr_allow(wr_allow), .quick_cnt_out(quick_cnt_out),
  .unused_cnt_out(unused_cnt_out), .misp_cnt_out(misp_cnt_out)
);

// File: tb/tb_vpf_access_filter.sv
`timescale 1ns/1ps
module tb_vpf_access_filter;

  localparam int QW = 2;
  localparam int UW = 2;
  localparam int MW = 3;
  localparam int QMAX = (1 << QW) - 1;
  localparam int UMAX = (1 << UW) - 1;
  localparam int MMAX = (1 << MW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [2:0]    op_class = '0;
  logic [QW-1:0] quick_cnt_in = '0;
  logic [UW-1:0] unused_cnt_in = '0;
  logic [MW-1:0] misp_cnt_in = '0;
  logic          retire = 1'b0, did_read = 1'b0;
  logic          ev_quick = 1'b0, ev_unused = 1'b0, ev_misp = 1'b0;
  logic          hist_clear = 1'b0;
  logic          out_valid, rd_allow, wr_allow;
  logic [QW-1:0] quick_cnt_out;
  logic [UW-1:0] unused_cnt_out;
  logic [MW-1:0] misp_cnt_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // pending expectation for the request driven one cycle earlier
  bit    pend = 1'b0;
  int    e_v, e_rd, e_wr, e_q, e_u, e_m;
  string t_rd, t_q, t_u, t_m;

  always #5 clk = ~clk;

  vpf_access_filter dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_class(op_class),
    .quick_cnt_in(quick_cnt_in), .unused_cnt_in(unused_cnt_in),
    .misp_cnt_in(misp_cnt_in), .retire(retire), .did_read(did_read),
    .ev_quick(ev_quick), .ev_unused(ev_unused), .ev_misp(ev_misp),
    .hist_clear(hist_clear), .out_valid(out_valid), .rd_allow(rd_allow),
    .wr_allow(wr_allow), .quick_cnt_out(quick_cnt_out),
    .unused_cnt_out(unused_cnt_out), .misp_cnt_out(misp_cnt_out)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int step_cnt(input int c, input int mx, input bit clr,
                                  input bit en, input bit up, input bit sticky);
    if (clr) return 0;
    if (!en) return c;
    if (sticky && c == mx) return c;
    if (up) return (c == mx) ? c : c + 1;
    return (c == 0) ? 0 : c - 1;
  endfunction

  task automatic compare();
    chk("R11", "out_valid", int'(out_valid), e_v);
    chk(t_rd, "rd_allow", int'(rd_allow), e_rd);
    chk("R9", "wr_allow", int'(wr_allow), e_wr);
    chk(t_q, "quick_cnt", int'(quick_cnt_out), e_q);
    chk(t_u, "unused_cnt", int'(unused_cnt_out), e_u);
    chk(t_m, "misp_cnt", int'(misp_cnt_out), e_m);
  endtask

  // Drive one request at the falling edge; check the previous one there too.
  task automatic step(input bit v, input int cls, input int q, input int u,
                      input int m, input bit ret, input bit dr, input bit eq,
                      input bit eu, input bit em, input bit clr);
    bit gate, en, cl;
    @(negedge clk);
    if (pend) compare();
    gate = (cls < 4);
    en   = v && ret && dr;
    cl   = v && clr;
    e_v  = v;
    e_wr = en;
    e_rd = (v && gate && (cl || (q < 2 && u < 2 && m < MMAX))) ? 1 : 0;
    if (!v)           t_rd = "R11";
    else if (!gate)   t_rd = "R1";
    else if (cl)      t_rd = "R10";
    else if (m == MMAX) t_rd = "R4";
    else if (q >= 2)  t_rd = "R2";
    else if (u >= 2)  t_rd = "R3";
    else              t_rd = "R5";
    e_q = step_cnt(q, QMAX, cl, en, eq, 1'b0);
    e_u = step_cnt(u, UMAX, cl, en, eu, 1'b0);
    e_m = step_cnt(m, MMAX, cl, en, em, 1'b1);
    t_q = cl ? "R10" : (en ? "R6" : "R8");
    t_u = t_q;
    t_m = cl ? "R10" : (m == MMAX ? "R7" : (en ? "R6" : "R8"));
    pend = 1'b1;
    in_valid = v; op_class = cls[2:0];
    quick_cnt_in = q[QW-1:0]; unused_cnt_in = u[UW-1:0]; misp_cnt_in = m[MW-1:0];
    retire = ret; did_read = dr; ev_quick = eq; ev_unused = eu; ev_misp = em;
    hist_clear = clr;
  endtask

  initial begin
    // R12: reset wins even with a busy request on the inputs
    in_valid = 1'b1; retire = 1'b1; did_read = 1'b1; misp_cnt_in = 3'd7;
    repeat (3) @(negedge clk);
    chk("R12", "out_valid", int'(out_valid), 0);
    chk("R12", "rd_allow", int'(rd_allow), 0);
    chk("R12", "wr_allow", int'(wr_allow), 0);
    chk("R12", "misp_cnt", int'(misp_cnt_out), 0);
    in_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;

    // Exhaustive sweep of every input combination.
    for (int cls = 0; cls < 8; cls++)
      for (int q = 0; q <= QMAX; q++)
        for (int u = 0; u <= UMAX; u++)
          for (int m = 0; m <= MMAX; m++)
            for (int k = 0; k < 64; k++)
              step(1'b1, cls, q, u, m, k[0], k[1], k[2], k[3], k[4], k[5]);

    // R11: idle requests give no permissions and keep history unchanged
    for (int k = 0; k < 16; k++)
      step(1'b0, 0, k % 4, (k / 4) % 4, k % 8, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);

    // Feedback histories: each instance reads if the model allows it,
    // then retires with random outcomes; history comes from the model.
    begin
      int q = 0, u = 0, m = 0;
      for (int n = 0; n < 4000; n++) begin
        int  cls;
        bit  rdok, clr, eq, eu, em;
        cls  = ($urandom % 10 < 8) ? ($urandom % 4) : (4 + $urandom % 4);
        clr  = ($urandom % 60) == 0;
        eq   = ($urandom % 3) == 0;
        eu   = ($urandom % 3) == 0;
        em   = ($urandom % 2) == 0;
        rdok = (cls < 4) && q < 2 && u < 2 && m < MMAX;
        step(1'b1, cls, q, u, m, 1'b1, rdok, eq, eu, em, clr);
        q = e_q; u = e_u; m = e_m;
      end
    end

    // R7: drive a history to the latch and confirm it holds on correct outcomes
    step(1'b1, 1, 0, 0, 6, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    step(1'b1, 1, 0, 0, 7, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b1, 1, 0, 0, 7, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);

    @(negedge clk);
    if (pend) compare();
    pend = 1'b0;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule